// File: doc/BRIEF.md
# JTAG Debug Port Scan Engine

This block sits on the target side of a JTAG debug port. It runs the TAP state machine from TCK and TMS. It holds a 4-bit instruction register and shifts one of three data paths: a fixed identification word, a one-bit bypass cell, or a 35-bit access register. The access register is shared by two kinds of transaction. A debug-port transaction reads or writes a small set of local registers. An access-port transaction issues a request on an internal bus toward a memory-access unit.

Every accepted transaction is launched at Update-DR. Its outcome appears in the Capture-DR of the next scan. Read results therefore arrive one scan late. To fetch the data of an access-port read, the host makes a follow-up scan. It can read the read-buffer register, which starts no new bus request, or it can simply make its next access. The access-port register address is built from a bank field held in the select register and the two address bits carried in the scan.

While an access-port request is still outstanding, a scan captures a WAIT acknowledge and its update is dropped. The power-up request bit of the control register is brought out as a level.

Top module: `jtag_dp_engine`

## Requirements
- R1: A synchronous active-high `rst`, or five TCK edges with TMS high from any state, puts the TAP in Test-Logic-Reset. This selects the identification instruction (4'hE). After `rst`, `tdo`, `ap_req` and `dbg_pwrup` are 0.
- R2: The instruction path is 4 bits wide and shifted LSB first. Capture-IR loads 4'b0001, and Update-IR makes the shifted value current.
- R3: With instruction 4'hE, Capture-DR loads the fixed 32-bit ID value 32'h4D2B8A13 (bit 0 is 1). Any code other than 4'hA, 4'hB or 4'hE selects a 1-bit bypass cell that captures 0.
- R4: Instructions 4'hA (debug-port access) and 4'hB (access-port access) select a 35-bit register, shifted LSB first. Shifted in: bits [34:3] are write data, bits [2:1] are address A, and bit 0 is the read flag (1 = read). Shifted out: bits [34:3] are the previous result and bits [2:0] are the acknowledge.
- R5: The acknowledge is 3'b010 when no access-port request is outstanding at Capture-DR. It is 3'b001 (WAIT) otherwise, and a scan that captured WAIT changes no register and issues no request.
- R6: A debug-port access decodes A as follows: 1 is the control register, 2 is the select register, 3 is the read buffer (writes ignored), and 0 has no register. A read makes that register's value the next result. A write, or A=0, makes the next result 0.
- R7: `dbg_pwrup` follows bit 28 of the control register. It changes only when that register is written.
- R8: An access-port access raises `ap_req` for exactly one TCK cycle. With it come `ap_addr` = {select[7:4], A, 2'b00}, `ap_sel` = select[31:24], `ap_write` = not read flag, and `ap_wdata` = the scanned data. The request stays outstanding until `ap_done`.
- R9: When `ap_done` ends a read, `ap_rdata` becomes the next result and is stored in the read buffer. A debug-port read of A=3 returns the read buffer without raising `ap_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, LSB of the active shift path in Shift-IR/DR, else 0 |
| ap_req | output | 1 | One-cycle access-port request strobe |
| ap_sel | output | 8 | Access-port number from select[31:24] |
| ap_addr | output | 8 | Access-port register address |
| ap_write | output | 1 | 1 for a write request, 0 for a read |
| ap_wdata | output | 32 | Write data of the request |
| ap_done | input | 1 | Completion strobe for the outstanding request |
| ap_rdata | input | 32 | Read data, valid with `ap_done` |
| dbg_pwrup | output | 1 | Debug power-up request level (control bit 28) |

## Verification
Each scan result is sampled at the falling edge that precedes the rising edge that shifts it. Captured data therefore reaches `tdo` one edge after Capture-DR, and the bench reads all 35 bits on the edges where the TAP sits in Shift-DR. Decoded effects appear on the rising edge that leaves Update-DR. The bench updates its reference model one nanosecond after that edge, so its per-cycle comparison of `dbg_pwrup` and its check of each `ap_req` pulse (seen at the next falling edge) line up with the RTL. The bench drives `ap_done` a configurable number of cycles after a request. A long delay holds the request outstanding across a full scan, so the WAIT path can be checked.

// File: rtl/jdp_pkg.sv
package jdp_pkg;
  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
  } tap_st_t;

  localparam logic [2:0] ACK_OK   = 3'b010;
  localparam logic [2:0] ACK_WAIT = 3'b001;
endpackage

// File: rtl/jdp_tap.sv
module jdp_tap
  import jdp_pkg::*;
(
  input  logic    tck,
  input  logic    rst,
  input  logic    tms,
  output tap_st_t st_o
);
  tap_st_t st_q, st_n;

  always_comb begin
    case (st_q)
      TLR:     st_n = tms ? TLR    : RTI;
      RTI:     st_n = tms ? SEL_DR : RTI;
      SEL_DR:  st_n = tms ? SEL_IR : CAP_DR;
      CAP_DR:  st_n = tms ? EX1_DR : SH_DR;
      SH_DR:   st_n = tms ? EX1_DR : SH_DR;
      EX1_DR:  st_n = tms ? UPD_DR : PAU_DR;
      PAU_DR:  st_n = tms ? EX2_DR : PAU_DR;
      EX2_DR:  st_n = tms ? UPD_DR : SH_DR;
      UPD_DR:  st_n = tms ? SEL_DR : RTI;
      SEL_IR:  st_n = tms ? TLR    : CAP_IR;
      CAP_IR:  st_n = tms ? EX1_IR : SH_IR;
      SH_IR:   st_n = tms ? EX1_IR : SH_IR;
      EX1_IR:  st_n = tms ? UPD_IR : PAU_IR;
      PAU_IR:  st_n = tms ? EX2_IR : PAU_IR;
      EX2_IR:  st_n = tms ? UPD_IR : SH_IR;
      UPD_IR:  st_n = tms ? SEL_DR : RTI;
      default: st_n = TLR;
    endcase
  end

  always_ff @(posedge tck) begin
    if (rst) st_q <= TLR;
    else     st_q <= st_n;
  end

  assign st_o = st_q;

  // R1
  tlr_hold_chk: assert property (@(posedge tck) disable iff (rst)
    (st_q == TLR && tms) |=> (st_q == TLR));

  // R2
  upd_exit_chk: assert property (@(posedge tck) disable iff (rst)
    ((st_q == UPD_IR || st_q == UPD_DR) && !tms) |=> (st_q == RTI));
endmodule

// File: rtl/jdp_xact.sv
module jdp_xact #(
  parameter int DW       = 32,
  parameter int APSEL_W  = 8,
  parameter int BANK_W   = 4,
  parameter int BANK_LSB = 4,
  parameter int PWR_BIT  = 28,
  localparam int AAW     = BANK_W + 4
) (
  input  logic               tck,
  input  logic               rst,
  input  logic               cap_i,
  input  logic               upd_i,
  input  logic               is_ap_i,
  input  logic               rnw_i,
  input  logic [1:0]         a_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic               ap_done_i,
  input  logic [DW-1:0]      ap_rdata_i,
  output logic               pend_o,
  output logic [DW-1:0]      result_o,
  output logic               ap_req_o,
  output logic [APSEL_W-1:0] ap_sel_o,
  output logic [AAW-1:0]     ap_addr_o,
  output logic               ap_write_o,
  output logic [DW-1:0]      ap_wdata_o,
  output logic               pwrup_o
);
  logic [DW-1:0] ctrl_q, sel_q, rdbuf_q, res_q;
  logic          pend_q, skip_q, rd_q;

  always_ff @(posedge tck) begin
    if (rst) begin
      ctrl_q     <= '0;
      sel_q      <= '0;
      rdbuf_q    <= '0;
      res_q      <= '0;
      pend_q     <= 1'b0;
      skip_q     <= 1'b0;
      rd_q       <= 1'b0;
      ap_req_o   <= 1'b0;
      ap_sel_o   <= '0;
      ap_addr_o  <= '0;
      ap_write_o <= 1'b0;
      ap_wdata_o <= '0;
    end else begin
      ap_req_o <= 1'b0;
      if (cap_i) skip_q <= pend_q;
      if (ap_done_i && pend_q) begin
        pend_q <= 1'b0;
        if (rd_q) begin
          res_q   <= ap_rdata_i;
          rdbuf_q <= ap_rdata_i;
        end
      end
      if (upd_i && !skip_q) begin
        if (is_ap_i) begin
          ap_req_o   <= 1'b1;
          pend_q     <= 1'b1;
          rd_q       <= rnw_i;
          ap_sel_o   <= sel_q[DW-1 -: APSEL_W];
          ap_addr_o  <= {sel_q[BANK_LSB +: BANK_W], a_i, 2'b00};
          ap_write_o <= !rnw_i;
          ap_wdata_o <= wdata_i;
          res_q      <= '0;
        end else begin
          case (a_i)
            2'd1: begin
              if (rnw_i) res_q <= ctrl_q;
              else begin ctrl_q <= wdata_i; res_q <= '0; end
            end
            2'd2: begin
              if (rnw_i) res_q <= sel_q;
              else begin sel_q <= wdata_i; res_q <= '0; end
            end
            2'd3:    res_q <= rnw_i ? rdbuf_q : '0;
            default: res_q <= '0;
          endcase
        end
      end
    end
  end

  assign pend_o   = pend_q;
  assign result_o = res_q;
  assign pwrup_o  = ctrl_q[PWR_BIT];

  // R8
  req_pulse_chk: assert property (@(posedge tck) disable iff (rst)
    ap_req_o |=> !ap_req_o);

  // R5
  no_req_busy_chk: assert property (@(posedge tck) disable iff (rst)
    (pend_q && $past(pend_q)) |-> !ap_req_o);

  // R7
  pwrup_hold_chk: assert property (@(posedge tck) disable iff (rst)
    !upd_i |=> $stable(pwrup_o));

  // R9
  rdbuf_hold_chk: assert property (@(posedge tck) disable iff (rst)
    !(ap_done_i && pend_q && rd_q) |=> $stable(rdbuf_q));
endmodule

// File: rtl/jtag_dp_engine.sv
module jtag_dp_engine
  import jdp_pkg::*;
#(
  parameter int DW                   = 32,
  parameter int IRW                  = 4,
  parameter int APSEL_W              = 8,
  parameter int BANK_W               = 4,
  parameter int PWR_BIT              = 28,
  parameter logic [IRW-1:0] IR_DPACC = 4'hA,
  parameter logic [IRW-1:0] IR_APACC = 4'hB,
  parameter logic [IRW-1:0] IR_IDENT = 4'hE,
  parameter logic [DW-1:0] IDENT_VAL = 32'h4D2B_8A13,
  localparam int AAW  = BANK_W + 4,
  localparam int ACCW = DW + 3
) (
  input  logic               tck,
  input  logic               rst,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               ap_req,
  output logic [APSEL_W-1:0] ap_sel,
  output logic [AAW-1:0]     ap_addr,
  output logic               ap_write,
  output logic [DW-1:0]      ap_wdata,
  input  logic               ap_done,
  input  logic [DW-1:0]      ap_rdata,
  output logic               dbg_pwrup
);
  tap_st_t         st;
  logic [IRW-1:0]  ir_sh, ir_q;
  logic [ACCW-1:0] dr_sh;
  logic            is_acc, is_id, pend;
  logic [DW-1:0]   result;

  jdp_tap u_tap (.tck(tck), .rst(rst), .tms(tms), .st_o(st));

  assign is_acc = (ir_q == IR_DPACC) || (ir_q == IR_APACC);
  assign is_id  = (ir_q == IR_IDENT);

  always_ff @(posedge tck) begin
    if (rst) begin
      ir_q  <= IR_IDENT;
      ir_sh <= '0;
    end else begin
      case (st)
        TLR:     ir_q  <= IR_IDENT;
        CAP_IR:  ir_sh <= {{(IRW-1){1'b0}}, 1'b1};
        SH_IR:   ir_sh <= {tdi, ir_sh[IRW-1:1]};
        UPD_IR:  ir_q  <= ir_sh;
        default: ;
      endcase
    end
  end

  always_ff @(posedge tck) begin
    if (rst) begin
      dr_sh <= '0;
    end else if (st == CAP_DR) begin
      if (is_acc)     dr_sh <= {result, pend ? ACK_WAIT : ACK_OK};
      else if (is_id) dr_sh <= {{(ACCW-DW){1'b0}}, IDENT_VAL};
      else            dr_sh <= '0;
    end else if (st == SH_DR) begin
      if (is_acc)     dr_sh <= {tdi, dr_sh[ACCW-1:1]};
      else if (is_id) dr_sh[DW-1:0] <= {tdi, dr_sh[DW-1:1]};
      else            dr_sh[0] <= tdi;
    end
  end

  assign tdo = (st == SH_IR) ? ir_sh[0] :
               (st == SH_DR) ? dr_sh[0] : 1'b0;

  jdp_xact #(
    .DW(DW), .APSEL_W(APSEL_W), .BANK_W(BANK_W), .BANK_LSB(4), .PWR_BIT(PWR_BIT)
  ) u_xact (
    .tck(tck), .rst(rst),
    .cap_i(st == CAP_DR && is_acc),
    .upd_i(st == UPD_DR && is_acc),
    .is_ap_i(ir_q == IR_APACC),
    .rnw_i(dr_sh[0]),
    .a_i(dr_sh[2:1]),
    .wdata_i(dr_sh[ACCW-1:3]),
    .ap_done_i(ap_done),
    .ap_rdata_i(ap_rdata),
    .pend_o(pend),
    .result_o(result),
    .ap_req_o(ap_req),
    .ap_sel_o(ap_sel),
    .ap_addr_o(ap_addr),
    .ap_write_o(ap_write),
    .ap_wdata_o(ap_wdata),
    .pwrup_o(dbg_pwrup)
  );

  // R1
  ir_ident_chk: assert property (@(posedge tck) disable iff (rst)
    (st == TLR) |=> (ir_q == IR_IDENT));

  // R4
  shift_idle_chk: assert property (@(posedge tck) disable iff (rst)
    (st != SH_DR && st != SH_IR) |-> (tdo == 1'b0));
endmodule

// File: tb/jtag_dp_engine_tb.sv
`timescale 1ns/1ps
module jtag_dp_engine_tb;
  localparam logic [31:0] IDV = 32'h4D2B_8A13;

  logic tck = 0, rst = 1, tms = 1, tdi = 0;
  logic tdo, ap_req, ap_write, dbg_pwrup;
  logic [7:0] ap_sel, ap_addr;
  logic [31:0] ap_wdata;
  logic ap_done = 0;
  logic [31:0] ap_rdata = 0;

  always #5 tck = ~tck;

  jtag_dp_engine u_dut (
    .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .tdo(tdo),
    .ap_req(ap_req), .ap_sel(ap_sel), .ap_addr(ap_addr), .ap_write(ap_write),
    .ap_wdata(ap_wdata), .ap_done(ap_done), .ap_rdata(ap_rdata),
    .dbg_pwrup(dbg_pwrup)
  );

  int errors = 0, checks = 0;
  bit mon_on = 0;
  logic [31:0] m_ctrl = 0, m_sel = 0, m_rdbuf = 0, m_res = 0;
  bit m_pend = 0;
  logic [31:0] mem [256];
  bit exp_valid = 0;
  logic [7:0] exp_addr = 0, exp_apsel = 0;
  bit exp_write = 0;
  logic [31:0] exp_wdata = 0;
  int ap_lat = 2, lat_cnt = 0;
  bit busy = 0;
  logic [7:0] r_addr = 0;
  bit r_write = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_up;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // per-cycle reference comparison of the power-up level (R7)
  always @(negedge tck) begin
    if (mon_on) chk("R7 pwrup level", dbg_pwrup, m_ctrl[28]);
  end

  // access-port responder and request checker (R8, R9, R5)
  always @(negedge tck) begin
    ap_done = 0;
    if (busy) begin
      if (lat_cnt == 0) begin
        ap_done = 1;
        busy = 0;
        if (!r_write) begin
          ap_rdata = mem[r_addr];
          m_res = ap_rdata;
          m_rdbuf = ap_rdata;
        end
        m_pend = 0;
      end else lat_cnt--;
    end
    if (mon_on && ap_req) begin
      chk("R8 request expected", exp_valid, 1);
      chk("R8 ap_addr", ap_addr, exp_addr);
      chk("R8 ap_sel", ap_sel, exp_apsel);
      chk("R8 ap_write", ap_write, exp_write);
      if (exp_write) chk("R8 ap_wdata", ap_wdata, exp_wdata);
      exp_valid = 0;
      r_addr = ap_addr;
      r_write = ap_write;
      if (ap_write) mem[ap_addr] = ap_wdata;
      busy = 1;
      lat_cnt = ap_lat;
    end
  end

  task automatic step(input bit ms, input bit di, output bit o);
    @(negedge tck);
    o = tdo;
    tms = ms;
    tdi = di;
  endtask

  task automatic idle(input int n);
    bit b;
    repeat (n) step(0, 0, b);
  endtask

  task automatic shift_ir(input logic [3:0] v);
    bit b;
    logic [3:0] o;
    step(1, 0, b); step(1, 0, b); step(0, 0, b); step(0, 0, b);
    for (int i = 0; i < 4; i++) begin
      step(i == 3, v[i], b);
      o[i] = b;
    end
    step(1, 0, b); step(0, 0, b);
    @(posedge tck); #1;
    chk("R2 IR capture", o, 4'b0001);
  endtask

  task automatic shift_dr(input int len, input logic [34:0] v, output logic [34:0] o);
    bit b;
    o = '0;
    step(1, 0, b); step(0, 0, b); step(0, 0, b);
    for (int i = 0; i < len; i++) begin
      step(i == len - 1, v[i], b);
      o[i] = b;
    end
    step(1, 0, b); step(0, 0, b);
    @(posedge tck); #1;
  endtask

  task automatic acc(input string tag, input logic [3:0] ir, input logic [1:0] a,
                     input bit rnw, input logic [31:0] d);
    logic [34:0] o;
    bit skip;
    logic [31:0] er;
    shift_ir(ir);
    skip = m_pend;
    er = m_res;
    if (ir == 4'hB && !skip) begin
      exp_valid = 1;
      exp_addr = {m_sel[7:4], a, 2'b00};
      exp_apsel = m_sel[31:24];
      exp_write = !rnw;
      exp_wdata = d;
    end
    shift_dr(35, {d, a, rnw}, o);
    chk({tag, " ack"}, o[2:0], skip ? 3'b001 : 3'b010);
    chk({tag, " data"}, o[34:3], er);
    if (!skip) begin
      if (ir == 4'hB) begin
        m_pend = 1;
        m_res = 0;
      end else begin
        case (a)
          2'd1: if (rnw) m_res = m_ctrl; else begin m_ctrl = d; m_res = 0; end
          2'd2: if (rnw) m_res = m_sel; else begin m_sel = d; m_res = 0; end
          2'd3: m_res = rnw ? m_rdbuf : 32'h0;
          default: m_res = 0;
        endcase
      end
    end
  endtask

  task automatic wait_ap;
    while (busy || m_pend) idle(1);
    idle(3);
  endtask

  initial begin
    repeat (40000) @(posedge tck);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [34:0] o;
    bit b;
    for (int i = 0; i < 256; i++) mem[i] = 32'h1000_0000 + i * 32'h0001_0203;
    repeat (3) @(posedge tck);
    @(negedge tck);
    rst = 0;
    @(negedge tck);
    // R1 reset state
    chk("R1 tdo after reset", tdo, 0);
    chk("R1 ap_req after reset", ap_req, 0);
    chk("R1 pwrup after reset", dbg_pwrup, 0);
    mon_on = 1;
    step(0, 0, b);
    // R1 R3 ident selected after reset
    shift_dr(32, 35'h0, o);
    chk("R3 ident value", o[31:0], IDV);
    // R3 bypass
    shift_ir(4'h3);
    shift_dr(2, 35'h1, o);
    chk("R3 bypass capture", o[0], 0);
    chk("R3 bypass passes tdi", o[1], 1);
    // R6 select write/read
    acc("R6 sel write", 4'hA, 2'd2, 0, 32'h05AA_00A0);
    acc("R6 sel read", 4'hA, 2'd2, 1, 32'h0);
    acc("R6 sel readback", 4'hA, 2'd0, 0, 32'h0);
    // R7 power-up request
    acc("R7 ctrl write", 4'hA, 2'd1, 0, 32'h1000_0000);
    chk("R7 pwrup set", dbg_pwrup, 1);
    acc("R6 ctrl read", 4'hA, 2'd1, 1, 32'h0);
    acc("R6 ctrl readback", 4'hA, 2'd3, 0, 32'hFFFF_FFFF);
    // R8 access-port write
    acc("R8 ap write", 4'hB, 2'd1, 0, 32'hCAFE_0001);
    wait_ap();
    // R9 access-port read fetched through read buffer
    acc("R9 ap read", 4'hB, 2'd1, 1, 32'h0);
    wait_ap();
    acc("R9 rdbuff fetch", 4'hA, 2'd3, 1, 32'h0);
    acc("R9 rdbuff again", 4'hA, 2'd0, 0, 32'h0);
    chk("R9 rdbuff value", m_rdbuf, 32'hCAFE_0001);
    // R9 read fetched by the next access
    acc("R9 ap read 2", 4'hB, 2'd3, 1, 32'h0);
    wait_ap();
    acc("R9 next access", 4'hB, 2'd2, 0, 32'h1234_5678);
    wait_ap();
    // R4 R5 wait path
    ap_lat = 60;
    acc("R5 ap read slow", 4'hB, 2'd2, 1, 32'h0);
    acc("R5 wait scan", 4'hA, 2'd2, 0, 32'h0000_0000);
    wait_ap();
    ap_lat = 2;
    acc("R5 after wait", 4'hA, 2'd2, 1, 32'h0);
    acc("R5 sel kept", 4'hA, 2'd0, 0, 32'h0);
    chk("R5 sel model", m_sel, 32'h05AA_00A0);
    // R1 five TMS high
    shift_ir(4'hA);
    repeat (5) step(1, 0, b);
    step(0, 0, b);
    shift_dr(32, 35'h0, o);
    chk("R1 ident after tms reset", o[31:0], IDV);
    idle(2);
    finish_up();
  end
endmodule